// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 64-bit register datapath and a memory that is organised as 64-bit words addressed by byte. For each request it adds two 64-bit operands to form the effective address. It then checks that address against the natural alignment of the access size: 1, 2, 4 or 8 bytes. An aligned request goes out to memory as a word address, a byte-enable mask and steered write data. A misaligned request is stopped in the same cycle and a fault flag is raised.

The lane layout is big-endian. Address offset 0 inside a word maps to the most significant byte of the data bus. A store places the low-order bytes of the source register so that the most significant of them lands at the lowest address. A load collects the addressed bytes in address order, then widens them to 64 bits with zeros or with copies of their top bit. The load result is registered, and a one-cycle done strobe marks it one cycle after the memory returns its data.

Top module: `lsu_be`

## Requirements
- R1: For an issued request, `mem_addr_o` equals (`op_y_i` + `op_z_i`) modulo 2^64 with its three low bits forced to zero.
- R2: `req_size_i` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. When the effective address is not a multiple of the size, `fault_o` is 1 and both `mem_req_o` and `mem_be_o` are 0 in that same cycle.
- R3: For an aligned valid request, `mem_req_o` is 1, `fault_o` is 0 and `mem_we_o` equals `req_store_i`.
- R4: Let off be the effective address bits [2:0] and n the access size in bytes. Bit k of `mem_be_o` is set exactly when off <= k < off+n.
- R5: On a store, bus lane k (bits [63-8k:56-8k]) carries source byte (off+n-1-k), counted from the least significant byte, for every enabled lane. All other lanes are zero.
- R6: An unsigned load (`req_signed_i`=0) returns the n bytes at lanes off..off+n-1, with lane off as the most significant, zero-extended to 64 bits.
- R7: A signed load returns the same bytes sign-extended from bit 8n-1.
- R8: `ld_done_o` is high for exactly the one cycle after each cycle in which `mem_rvalid_i` is high. `ld_data_o` then holds the result until the next one arrives.
- R9: While `rst_ni` is low, `ld_done_o` and `ld_data_o` are zero.
- R10: With `req_valid_i` low, `mem_req_o`, `fault_o` and `mem_be_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Size code: 0 byte, 1 wyde, 2 tetra, 3 octa |
| req_signed_i | input | 1 | Load extension: 1 signed, 0 unsigned |
| op_y_i | input | 64 | First address operand |
| op_z_i | input | 64 | Second address operand |
| st_data_i | input | 64 | Store source register |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 64 | Word-aligned memory address |
| mem_be_o | output | 8 | Byte enables, bit k = offset k |
| mem_wdata_o | output | 64 | Steered write data |
| fault_o | output | 1 | Alignment fault |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data word |
| ld_done_o | output | 1 | Load result strobe |
| ld_data_o | output | 64 | Extended load result |

## Verification
The request-side outputs are combinational: the address, enables, write data, request strobe and fault follow the inputs in the same cycle. The bench therefore drives a request on the falling edge and samples those outputs before the next rising edge. The load result passes through one register. The bench drives `mem_rvalid_i` for one cycle after the rising edge that issues the load, checks `ld_done_o` and `ld_data_o` on the falling edge after the capturing edge, and checks one falling edge later that the strobe has dropped. The bench sweeps every size, offset, direction and extension mode with two data patterns: one with every byte's top bit clear and one with every byte's top bit set.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WYDE  = 2'd1,
    SZ_TETRA = 2'd2,
    SZ_OCTA  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_addr_chk.sv
module lsu_addr_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LANES  = 8,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned CW    = OFF_W + 2
) (
  input  logic [ADDR_W-1:0] op_y_i,
  input  logic [ADDR_W-1:0] op_z_i,
  input  logic [CW-1:0]     nbytes_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              misaligned_o,
  output logic [LANES-1:0]  lane_mask_o
);
  logic [ADDR_W-1:0] ea;
  logic [CW-1:0]     off_w;
  logic [CW-1:0]     end_w;

  assign ea          = op_y_i + op_z_i;
  assign off_o       = ea[OFF_W-1:0];
  assign word_addr_o = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign off_w       = CW'(off_o);
  assign end_w       = off_w + nbytes_i;
  // size is a power of two: aligned iff offset bits below it are clear
  assign misaligned_o = |(off_w & (nbytes_i - CW'(1)));

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    localparam logic [CW-1:0] LANE_IDX = CW'(k);
    assign lane_mask_o[k] = (LANE_IDX >= off_w) && (LANE_IDX < end_w);
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANES * 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned CW     = OFF_W + 2
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CW-1:0]     nbytes_i,
  input  logic [LANES-1:0]  lane_mask_i,
  output logic [DATA_W-1:0] wdata_o
);
  logic [CW-1:0] last_w;
  assign last_w = CW'(off_i) + nbytes_i - CW'(1);

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    localparam logic [CW-1:0] LANE_IDX = CW'(k);
    logic [CW-1:0]    idx_full;
    logic [OFF_W-1:0] idx;
    assign idx_full = last_w - LANE_IDX;
    assign idx      = idx_full[OFF_W-1:0];
    // lane 0 is the lowest address, carried on the top byte
    assign wdata_o[DATA_W-1-8*k -: 8] = lane_mask_i[k] ? src_i[8*idx +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext #(
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANES * 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned CW     = OFF_W + 2
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CW-1:0]     nbytes_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] value_o
);
  logic [CW-1:0] last_w;
  logic          top_bit;
  logic [7:0]    fill;

  assign last_w  = CW'(off_i) + nbytes_i - CW'(1);
  // most significant loaded byte sits at lane off
  assign top_bit = rdata_i[DATA_W-1-8*int'(off_i)];
  assign fill    = {8{signed_i & top_bit}};

  for (genvar j = 0; j < int'(LANES); j++) begin : g_byte
    localparam logic [CW-1:0] BYTE_IDX = CW'(j);
    logic [CW-1:0]    lane_full;
    logic [OFF_W-1:0] lane;
    logic             used;
    assign used      = BYTE_IDX < nbytes_i;
    assign lane_full = last_w - BYTE_IDX;
    assign lane      = lane_full[OFF_W-1:0];
    assign value_o[8*j +: 8] = used ? rdata_i[DATA_W-1-8*int'(lane) -: 8] : fill;
  end
endmodule

// File: rtl/lsu_be.sv
module lsu_be
  import lsu_be_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANES * 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned CW     = OFF_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [ADDR_W-1:0] op_y_i,
  input  logic [ADDR_W-1:0] op_z_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              fault_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_done_o,
  output logic [DATA_W-1:0] ld_data_o
);
  acc_size_e        size;
  logic [CW-1:0]    nbytes;
  logic [ADDR_W-1:0] word_addr;
  logic [OFF_W-1:0] off;
  logic             misaligned;
  logic [LANES-1:0] lane_mask;
  logic [DATA_W-1:0] wdata;
  logic             issue;

  logic [OFF_W-1:0] ctx_off_q;
  logic [CW-1:0]    ctx_nbytes_q;
  logic             ctx_signed_q;
  logic [DATA_W-1:0] ld_value;

  assign size   = acc_size_e'(req_size_i);
  assign nbytes = CW'(1) << size;

  lsu_addr_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
    .op_y_i      (op_y_i),
    .op_z_i      (op_z_i),
    .nbytes_i    (nbytes),
    .word_addr_o (word_addr),
    .off_o       (off),
    .misaligned_o(misaligned),
    .lane_mask_o (lane_mask)
  );

  lsu_store_steer #(.LANES(LANES)) u_steer (
    .src_i      (st_data_i),
    .off_i      (off),
    .nbytes_i   (nbytes),
    .lane_mask_i(lane_mask),
    .wdata_o    (wdata)
  );

  assign issue       = req_valid_i && !misaligned;
  assign fault_o     = req_valid_i && misaligned;
  assign mem_req_o   = issue;
  assign mem_we_o    = issue && req_store_i;
  assign mem_addr_o  = issue ? word_addr : '0;
  assign mem_be_o    = issue ? lane_mask : '0;
  assign mem_wdata_o = (issue && req_store_i) ? wdata : '0;

  // load context held until the data returns; one load outstanding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_off_q    <= '0;
      ctx_nbytes_q <= CW'(1);
      ctx_signed_q <= 1'b0;
    end else if (issue && !req_store_i) begin
      ctx_off_q    <= off;
      ctx_nbytes_q <= nbytes;
      ctx_signed_q <= req_signed_i;
    end
  end

  lsu_load_ext #(.LANES(LANES)) u_ext (
    .rdata_i (mem_rdata_i),
    .off_i   (ctx_off_q),
    .nbytes_i(ctx_nbytes_q),
    .signed_i(ctx_signed_q),
    .value_o (ld_value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_done_o <= 1'b0;
      ld_data_o <= '0;
    end else begin
      ld_done_o <= mem_rvalid_i;
      if (mem_rvalid_i) ld_data_o <= ld_value;
    end
  end
endmodule

// File: rtl/lsu_be_chk.sv
module lsu_be_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LANES  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [1:0]        req_size_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_be_o,
  input logic              fault_o,
  input logic              mem_rvalid_i,
  input logic              ld_done_o
);
  a_r1_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  a_r2_fault_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_req_o && mem_be_o == '0));

  a_r3_we_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_we_o == req_store_i));

  a_r4_be_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $countones(mem_be_o) == (1 << req_size_i));

  a_r8_done_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |=> ld_done_o);

  a_r8_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rvalid_i |=> !ld_done_o);

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_req_o && !fault_o && mem_be_o == '0));
endmodule

bind lsu_be lsu_be_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .req_size_i  (req_size_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .fault_o     (fault_o),
  .mem_rvalid_i(mem_rvalid_i),
  .ld_done_o   (ld_done_o)
);

// File: tb/lsu_be_bench.sv
module lsu_be_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic        req_signed_i = 1'b0;
  logic [63:0] op_y_i = '0;
  logic [63:0] op_z_i = '0;
  logic [63:0] st_data_i = '0;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [63:0] mem_addr_o;
  logic [7:0]  mem_be_o;
  logic [63:0] mem_wdata_o;
  logic        fault_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        ld_done_o;
  logic [63:0] ld_data_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsu_be u_lsu_be (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(input int n, input int off);
    logic [7:0] m = '0;
    for (int k = 0; k < 8; k++) if (k >= off && k < off + n) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_wdata(input int n, input int off, input logic [63:0] src);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++)
      if (k >= off && k < off + n) w[63-8*k -: 8] = src[8*(off+n-1-k) +: 8];
    return w;
  endfunction

  function automatic logic [63:0] exp_load(input int n, input int off, input bit sg, input logic [63:0] rd);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(rd[63-8*(off+i) -: 8]);
    if (sg && v[8*n-1]) for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] y, z, src, rd, ea;
    int n;
    repeat (2) @(negedge clk_i);
    chk(ld_done_o == 1'b0, "R9 done in reset", 64'(ld_done_o), 64'd0);
    chk(ld_data_o == '0, "R9 data in reset", ld_data_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!mem_req_o && !fault_o && mem_be_o == '0, "R10 idle",
        {mem_req_o, fault_o, mem_be_o}, 64'd0);

    for (int p = 0; p < 2; p++)
    for (int sz = 0; sz < 4; sz++)
    for (int off = 0; off < 8; off++)
    for (int st = 0; st < 2; st++)
    for (int sg = 0; sg < 2; sg++) begin
      n   = 1 << sz;
      y   = (sz[0]) ? 64'hFFFF_FFFF_FFFF_FFF8 : 64'h0000_1234_5678_9A00;
      z   = 64'h40 * 64'(sz + 1) + 64'(off);
      ea  = y + z;
      src = p ? 64'h8899_AABB_CCDD_EEFF : 64'h0123_4567_89AB_CDEF;
      rd  = p ? 64'h80F1_92E3_A4D5_B6C7 : 64'h7F61_5243_3425_1607;
      @(negedge clk_i);
      req_valid_i  = 1'b1;
      req_store_i  = st[0];
      req_size_i   = sz[1:0];
      req_signed_i = sg[0];
      op_y_i = y; op_z_i = z; st_data_i = src;
      #1;
      if ((off % n) != 0) begin
        chk(fault_o && !mem_req_o && mem_be_o == '0, "R2 misaligned fault",
            {fault_o, mem_req_o, mem_be_o}, 64'h200);
        @(negedge clk_i);
        req_valid_i = 1'b0;
      end else begin
        chk(mem_req_o && !fault_o && mem_we_o == st[0], "R3 aligned issue",
            {mem_req_o, fault_o, mem_we_o}, {1'b1, 1'b0, st[0]});
        chk(mem_addr_o == {ea[63:3], 3'b000}, "R1 address", mem_addr_o, {ea[63:3], 3'b000});
        chk(mem_be_o == exp_be(n, off), "R4 byte enables", 64'(mem_be_o), 64'(exp_be(n, off)));
        if (st != 0) begin
          chk(mem_wdata_o == exp_wdata(n, off, src), "R5 store lanes",
              mem_wdata_o, exp_wdata(n, off, src));
          @(negedge clk_i);
          req_valid_i = 1'b0;
        end else begin
          @(negedge clk_i);
          req_valid_i  = 1'b0;
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = rd;
          @(negedge clk_i);
          mem_rvalid_i = 1'b0;
          mem_rdata_i  = '0;
          chk(ld_done_o == 1'b1, "R8 done strobe", 64'(ld_done_o), 64'd1);
          if (sg != 0)
            chk(ld_data_o == exp_load(n, off, 1'b1, rd), "R7 signed load",
                ld_data_o, exp_load(n, off, 1'b1, rd));
          else
            chk(ld_data_o == exp_load(n, off, 1'b0, rd), "R6 unsigned load",
                ld_data_o, exp_load(n, off, 1'b0, rd));
          @(negedge clk_i);
          chk(ld_done_o == 1'b0, "R8 single pulse", 64'(ld_done_o), 64'd0);
          chk(ld_data_o == exp_load(n, off, sg[0], rd), "R8 data held",
              ld_data_o, exp_load(n, off, sg[0], rd));
        end
      end
      #1;
      chk(!mem_req_o && !fault_o, "R10 idle after op", {mem_req_o, fault_o}, 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule